// File: doc/BRIEF.md
# Device Command Dispatcher with Seconds Clock

This block sits behind a byte-serial handshake engine that collects a complete host packet. When a packet arrives, the block reads its leading type byte. Only device-command packets (type 1) are handled here. Packets of any other type, such as peripheral-bus, error, timer, power, I2C and power-manager packets, are dropped without a reply and are left to other logic.

For a device command, the block checks the argument count against the exact count that command requires. If the count is correct, the command runs and an acknowledge reply is built. If the count is wrong, or the command byte is unknown, an error reply is built. Each reply is presented for one cycle as a flat byte vector with a length and a valid strobe.

The block also keeps a 32-bit seconds clock that counts from 1 January 1904. A 1 Hz tick advances the clock, and commands can read it or load it. The block holds the peripheral polling settings (enable, period and device mask) and produces one-cycle power-down and system-reset request pulses.

Top module: `ctl_cmd_dispatch`

## Requirements
Packet layout: byte 0 is the type and byte 1 is the command code. Argument bytes start at byte 2, and the argument count is `pkt_len - 2`. Reply byte k sits at bits `[8k+7:8k]` of `rply_data`, and every unused byte is zero. A reply appears, with `rply_valid` high for one cycle, in the cycle after the packet is accepted.

- R1: A packet whose type byte is not 1, or a type-1 packet shorter than 2 bytes, produces no reply and changes no setting.
- R2: A command that is accepted replies with 3 bytes (1, 0, command byte), plus any result bytes.
- R3: Any command code other than 0x01, 0x03, 0x09, 0x0A, 0x0E, 0x11, 0x14, 0x19 or 0x21 replies with 4 bytes: 2, 2, 1, command byte.
- R4: A known command whose argument count differs from its required count replies with 4 bytes: 2, 5, 1, command byte. The required counts are 0 for 0x03, 0x0A and 0x11; 1 for 0x01, 0x0E, 0x14 and 0x21; 2 for 0x19; and 4 for 0x09. The command then has no effect.
- R5: Get-time (0x03) replies with 7 bytes. The last four bytes are the seconds value held before the accepting edge, most significant byte first.
- R6: Set-time (0x09) loads its four argument bytes into the clock, first byte most significant. A load takes priority over a tick in the same cycle.
- R7: After reset, the clock holds `START_UNIX + 2082844800`, which is 2082844800 with the default parameters.
- R8: Set-rate (0x14) stores its byte as the poll period. A value of 0 is rejected with error code 5. The period resets to 20.
- R9: Set-device-list (0x19) stores the poll mask as {first argument, second argument}. The mask resets to 0xFFFF.
- R10: Autopoll (0x01) sets `autopoll_en` when its argument is nonzero and clears it when the argument is zero. It resets to 0.
- R11: Power-down (0x0A) and system-reset (0x11) each pulse their request output for one cycle, together with the reply. File-server-flag (0x0E) and power-messages (0x21) are acknowledged and change nothing.
- R12: Each `sec_tick` cycle adds one to the clock, wrapping from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Complete packet present this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_data | input | 8*IN_BYTES | Packet bytes, byte 0 in the low bits |
| sec_tick | input | 1 | One-second tick |
| rply_valid | output | 1 | Reply present this cycle |
| rply_len | output | OLEN_W | Reply length in bytes |
| rply_data | output | 8*OUT_BYTES | Reply bytes, byte 0 in the low bits |
| autopoll_en | output | 1 | Polling enabled |
| poll_rate | output | 8 | Poll period in milliseconds |
| poll_mask | output | 16 | Device poll mask |
| pwr_down_req | output | 1 | Power-down request pulse |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The hardest situations to reach are the ones where a clock tick lands in the same cycle as a clock command. These are a set-time that must override a tick, and a get-time that must report the value from before the tick. The bench drives the tick and the packet in the same cycle for both cases and then reads the clock back.

The bench also sweeps every command code with every argument count from 0 to 6. This reaches each wrong-count error path. Because the sweep includes set-time, the clock is reloaded with values that follow from the sweep, and a behavioural model is updated in step. The zero-argument cases for set-rate and autopoll, and the clock wrap, are forced directly.

// File: rtl/ctl_cmd_pkg.sv
package ctl_cmd_pkg;
  localparam logic [7:0] PKT_BUS   = 8'd0;
  localparam logic [7:0] PKT_DEV   = 8'd1;
  localparam logic [7:0] PKT_ERR   = 8'd2;

  localparam logic [7:0] ERR_UNKNOWN  = 8'd2;
  localparam logic [7:0] ERR_BADPARAM = 8'd5;

  localparam logic [7:0] CMD_AUTOPOLL = 8'h01;
  localparam logic [7:0] CMD_GETTIME  = 8'h03;
  localparam logic [7:0] CMD_SETTIME  = 8'h09;
  localparam logic [7:0] CMD_PWRDN    = 8'h0A;
  localparam logic [7:0] CMD_FSFLAG   = 8'h0E;
  localparam logic [7:0] CMD_SYSRST   = 8'h11;
  localparam logic [7:0] CMD_RATE     = 8'h14;
  localparam logic [7:0] CMD_DEVLIST  = 8'h19;
  localparam logic [7:0] CMD_PWRMSG   = 8'h21;

  // seconds between the 1904 and 1970 epochs
  localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;

  typedef enum logic [2:0] {
    OP_NOP, OP_AUTOPOLL, OP_GETTIME, OP_SETTIME,
    OP_PWRDN, OP_SYSRST, OP_RATE, OP_DEVLIST
  } op_e;
endpackage

// File: rtl/ctl_sec_clock.sv
module ctl_sec_clock #(
  parameter int          W    = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] sec
);
  always_ff @(posedge clk) begin
    if (rst)       sec <= INIT;
    else if (load) sec <= load_val;
    else if (tick) sec <= sec + 1'b1;
  end

  a_r12_tick_advance: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> sec == W'($past(sec) + 1'b1));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> sec == $past(load_val));
endmodule

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
  import ctl_cmd_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [7:0]    cmd,
  input  logic [CW-1:0] argc,
  input  logic [7:0]    arg0,
  output logic          known,
  output logic          args_ok,
  output op_e           op
);
  logic [CW-1:0] need;
  logic          value_ok;

  always_comb begin
    known    = 1'b1;
    op       = OP_NOP;
    need     = '0;
    value_ok = 1'b1;
    case (cmd)
      CMD_AUTOPOLL: begin op = OP_AUTOPOLL; need = CW'(1); end
      CMD_GETTIME:  begin op = OP_GETTIME;  need = CW'(0); end
      CMD_SETTIME:  begin op = OP_SETTIME;  need = CW'(4); end
      CMD_PWRDN:    begin op = OP_PWRDN;    need = CW'(0); end
      CMD_SYSRST:   begin op = OP_SYSRST;   need = CW'(0); end
      CMD_RATE:     begin op = OP_RATE;     need = CW'(1); value_ok = (arg0 != 8'd0); end
      CMD_DEVLIST:  begin op = OP_DEVLIST;  need = CW'(2); end
      CMD_FSFLAG:   need = CW'(1);
      CMD_PWRMSG:   need = CW'(1);
      default:      known = 1'b0;
    endcase
    args_ok = known && (argc == need) && value_ok;
  end
endmodule

// File: rtl/ctl_cmd_dispatch.sv
module ctl_cmd_dispatch
  import ctl_cmd_pkg::*;
#(
  parameter int          IN_BYTES   = 8,
  parameter int          OUT_BYTES  = 8,
  parameter logic [31:0] START_UNIX = 32'd0,
  parameter logic [7:0]  RATE_INIT  = 8'd20,
  localparam int         LEN_W      = $clog2(IN_BYTES + 1),
  localparam int         OLEN_W     = $clog2(OUT_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pkt_valid,
  input  logic [LEN_W-1:0]       pkt_len,
  input  logic [8*IN_BYTES-1:0]  pkt_data,
  input  logic                   sec_tick,
  output logic                   rply_valid,
  output logic [OLEN_W-1:0]      rply_len,
  output logic [8*OUT_BYTES-1:0] rply_data,
  output logic                   autopoll_en,
  output logic [7:0]             poll_rate,
  output logic [15:0]            poll_mask,
  output logic                   pwr_down_req,
  output logic                   sys_reset_req
);
  localparam int ARGS = 4;

  logic [7:0]       b_type, b_cmd;
  logic [7:0]       arg [ARGS];
  logic [LEN_W-1:0] argc;
  logic             accept, known, args_ok, exec;
  op_e              op;
  logic [31:0]      sec;
  logic [8*OUT_BYTES-1:0] nxt_data;
  logic [OLEN_W-1:0]      nxt_len;

  assign b_type = pkt_data[7:0];
  assign b_cmd  = pkt_data[15:8];
  assign argc   = pkt_len - LEN_W'(2);

  for (genvar j = 0; j < ARGS; j++) begin : g_arg
    if (j + 2 < IN_BYTES) begin : g_in
      assign arg[j] = pkt_data[8*(j+2) +: 8];
    end else begin : g_zero
      assign arg[j] = 8'd0;
    end
  end

  assign accept = pkt_valid && (b_type == PKT_DEV) && (pkt_len >= LEN_W'(2));
  assign exec   = accept && args_ok;

  ctl_cmd_decode #(.CW(LEN_W)) u_dec (
    .cmd     (b_cmd),
    .argc    (argc),
    .arg0    (arg[0]),
    .known   (known),
    .args_ok (args_ok),
    .op      (op)
  );

  ctl_sec_clock #(.W(32), .INIT(START_UNIX + EPOCH_SHIFT)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .tick     (sec_tick),
    .load     (exec && op == OP_SETTIME),
    .load_val ({arg[0], arg[1], arg[2], arg[3]}),
    .sec      (sec)
  );

  always_comb begin
    nxt_data = '0;
    if (!args_ok) begin
      nxt_data[7:0]   = PKT_ERR;
      nxt_data[15:8]  = known ? ERR_BADPARAM : ERR_UNKNOWN;
      nxt_data[23:16] = PKT_DEV;
      nxt_data[31:24] = b_cmd;
      nxt_len         = OLEN_W'(4);
    end else begin
      nxt_data[7:0]   = PKT_DEV;
      nxt_data[15:8]  = 8'd0;
      nxt_data[23:16] = b_cmd;
      nxt_len         = OLEN_W'(3);
      if (op == OP_GETTIME) begin
        nxt_data[31:24] = sec[31:24];
        nxt_data[39:32] = sec[23:16];
        nxt_data[47:40] = sec[15:8];
        nxt_data[55:48] = sec[7:0];
        nxt_len         = OLEN_W'(7);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rply_valid    <= 1'b0;
      rply_len      <= '0;
      rply_data     <= '0;
      autopoll_en   <= 1'b0;
      poll_rate     <= RATE_INIT;
      poll_mask     <= 16'hFFFF;
      pwr_down_req  <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      rply_valid    <= accept;
      pwr_down_req  <= exec && op == OP_PWRDN;
      sys_reset_req <= exec && op == OP_SYSRST;
      if (accept) begin
        rply_len  <= nxt_len;
        rply_data <= nxt_data;
      end
      if (exec) begin
        case (op)
          OP_AUTOPOLL: autopoll_en <= (arg[0] != 8'd0);
          OP_RATE:     poll_rate   <= arg[0];
          OP_DEVLIST:  poll_mask   <= {arg[0], arg[1]};
          default: ;
        endcase
      end
    end
  end

  a_r1_reply_needs_dev_pkt: assert property (@(posedge clk) disable iff (rst)
    rply_valid |-> ($past(pkt_valid) && $past(pkt_data[7:0]) == PKT_DEV));

  a_r2_reply_len_legal: assert property (@(posedge clk) disable iff (rst)
    rply_valid |-> (rply_len == OLEN_W'(3) || rply_len == OLEN_W'(4) || rply_len == OLEN_W'(7)));

  a_r3_err_is_four: assert property (@(posedge clk) disable iff (rst)
    (rply_valid && rply_data[7:0] == PKT_ERR) |-> rply_len == OLEN_W'(4));

  a_r8_rate_nonzero: assert property (@(posedge clk) disable iff (rst)
    poll_rate != 8'd0);

  a_r11_pulse_with_ack: assert property (@(posedge clk) disable iff (rst)
    (pwr_down_req || sys_reset_req) |-> (rply_valid && rply_data[7:0] == PKT_DEV));
endmodule

// File: tb/ctl_cmd_dispatch_bench.sv
module ctl_cmd_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_valid = 1'b0;
  logic [3:0]  pkt_len = '0;
  logic [63:0] pkt_data = '0;
  logic        sec_tick = 1'b0;
  logic        rply_valid;
  logic [3:0]  rply_len;
  logic [63:0] rply_data;
  logic        autopoll_en;
  logic [7:0]  poll_rate;
  logic [15:0] poll_mask;
  logic        pwr_down_req, sys_reset_req;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_sec  = 32'd2082844800;
  logic [7:0]  m_rate = 8'd20;
  logic [15:0] m_mask = 16'hFFFF;
  logic        m_auto = 1'b0;

  always #10 clk = ~clk;

  ctl_cmd_dispatch u_ctl_cmd_dispatch (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_data(pkt_data), .sec_tick(sec_tick), .rply_valid(rply_valid),
    .rply_len(rply_len), .rply_data(rply_data), .autopoll_en(autopoll_en),
    .poll_rate(poll_rate), .poll_mask(poll_mask),
    .pwr_down_req(pwr_down_req), .sys_reset_req(sys_reset_req)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic settings_chk();
    chk("R8", "poll_rate", 64'(poll_rate), 64'(m_rate));
    chk("R9", "poll_mask", 64'(poll_mask), 64'(m_mask));
    chk("R10", "autopoll_en", 64'(autopoll_en), 64'(m_auto));
  endtask

  task automatic send_pkt(input logic [63:0] d, input int len, input logic tk);
    @(negedge clk);
    pkt_data = d; pkt_len = 4'(len); pkt_valid = 1'b1; sec_tick = tk;
    @(negedge clk);
    pkt_valid = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    m_sec = m_sec + 1'b1;
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input int argc,
                         input logic [47:0] args, input logic tk, input string note);
    logic [63:0] d, ed;
    int need, elen;
    bit known, ok;
    string tag;
    d = '0; d[7:0] = 8'd1; d[15:8] = cmd;
    for (int j = 0; j < argc; j++) d[8*(j+2) +: 8] = args[8*j +: 8];
    known = 1'b1; need = 0;
    case (cmd)
      8'h01: need = 1;  8'h03: need = 0;  8'h09: need = 4;
      8'h0A: need = 0;  8'h0E: need = 1;  8'h11: need = 0;
      8'h14: need = 1;  8'h19: need = 2;  8'h21: need = 1;
      default: known = 1'b0;
    endcase
    ok = known && argc == need && !(cmd == 8'h14 && args[7:0] == 8'd0);
    ed = '0;
    if (!known) begin
      ed = {32'd0, cmd, 8'd1, 8'd2, 8'd2}; elen = 4; tag = "R3";
    end else if (!ok) begin
      ed = {32'd0, cmd, 8'd1, 8'd5, 8'd2}; elen = 4; tag = "R4";
    end else if (cmd == 8'h03) begin
      ed = {8'd0, m_sec[7:0], m_sec[15:8], m_sec[23:16], m_sec[31:24], cmd, 8'd0, 8'd1};
      elen = 7; tag = "R5";
    end else begin
      ed = {40'd0, cmd, 8'd0, 8'd1}; elen = 3; tag = (cmd == 8'h09) ? "R6" : "R2";
    end
    send_pkt(d, argc + 2, tk);
    chk({note, tag}, "rply_valid", 64'(rply_valid), 64'd1);
    chk({note, tag}, "rply_len", 64'(rply_len), 64'(elen));
    chk({note, tag}, "rply_data", rply_data, ed);
    chk({note, "R11"}, "pwr_down_req", 64'(pwr_down_req), 64'(ok && cmd == 8'h0A));
    chk({note, "R11"}, "sys_reset_req", 64'(sys_reset_req), 64'(ok && cmd == 8'h11));
    if (ok) begin
      case (cmd)
        8'h01: m_auto = (args[7:0] != 8'd0);
        8'h14: m_rate = args[7:0];
        8'h19: m_mask = {args[7:0], args[15:8]};
        default: ;
      endcase
    end
    if (ok && cmd == 8'h09) m_sec = {args[7:0], args[15:8], args[23:16], args[31:24]};
    else if (tk) m_sec = m_sec + 1'b1;
    settings_chk();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R1", "rply_valid after reset", 64'(rply_valid), 64'd0);
    chk("R11", "pulses after reset", 64'({pwr_down_req, sys_reset_req}), 64'd0);
    settings_chk();
    run_cmd(8'h03, 0, '0, 1'b0, "R7 ");

    // R12: ticks and wrap
    for (int i = 0; i < 3; i++) tick();
    run_cmd(8'h03, 0, '0, 1'b0, "R12 ");
    run_cmd(8'h09, 4, 48'hFF_FF_FF_FF, 1'b0, "R12 ");
    tick();
    run_cmd(8'h03, 0, '0, 1'b0, "R12 wrap ");

    // R6: load beats tick; R5: get-time reports value before a tick
    run_cmd(8'h09, 4, 48'h44_33_22_11, 1'b1, "R6 tick ");
    run_cmd(8'h03, 0, '0, 1'b0, "R6 ");
    run_cmd(8'h03, 0, '0, 1'b1, "R5 tick ");
    run_cmd(8'h03, 0, '0, 1'b0, "R5 ");

    // R8 zero rate rejected, R10 enable then disable
    run_cmd(8'h14, 1, 48'h00, 1'b0, "R8 zero ");
    run_cmd(8'h14, 1, 48'h07, 1'b0, "R8 ");
    run_cmd(8'h01, 1, 48'h80, 1'b0, "R10 on ");
    run_cmd(8'h01, 1, 48'h00, 1'b0, "R10 off ");
    run_cmd(8'h19, 2, 48'h5A_A5, 1'b0, "R9 ");

    // R1: other packet types, short device packets
    for (int t = 0; t < 256; t++) begin
      if (t != 1) begin
        send_pkt({40'h0, 8'h00, 8'h19, 8'(t)}, 4, 1'b0);
        chk("R1", "no reply for other type", 64'(rply_valid), 64'd0);
        settings_chk();
      end
    end
    for (int l = 0; l < 2; l++) begin
      send_pkt({48'h0, 8'h14, 8'h01}, l, 1'b0);
      chk("R1", "no reply for short packet", 64'(rply_valid), 64'd0);
    end

    // sweep every command code and argument count 0..6
    for (int c = 0; c < 256; c++) begin
      for (int a = 0; a <= 6; a++) begin
        logic [47:0] args;
        for (int j = 0; j < 6; j++) args[8*j +: 8] = 8'((c * 29 + a * 7 + j * 53 + 1) & 255);
        run_cmd(8'(c), a, args, 1'b0, "sweep ");
      end
    end
    run_cmd(8'h03, 0, '0, 1'b0, "final ");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule